// File: doc/BRIEF.md
# Activated Down-Count Watchdog

This block guards a processor against runaway code. A single byte-wide control register holds an activation flag in its top bit and a 7-bit down-counter in the lower bits. Once software sets the activation flag, the counter steps down by one on every prescaled tick. Software must reload the counter by writing the register before bit 6 of the count drops to zero. If it does not, or if the processor requests HALT while the watchdog is active, the block drives a reset pulse of fixed length to the system reset logic.

Software can only set the activation flag. Writing a zero to it has no effect, and only a reset, whether external or self-generated, clears it. While the reset pulse is being driven, the register is held at its power-up value. When the pulse ends, the watchdog is left inactive with a full count. The block has no interrupt output.

Top module: `wdog_top`

## Requirements
- R1: After synchronous reset, rd_data reads 7Fh (bit 7 = activation flag = 0, bits 6..0 = count = all ones) and wdg_rst is 0.
- R2: A write with bit 7 set activates the watchdog. A later write with bit 7 clear leaves the flag at 1, as seen in rd_data[7].
- R3: While inactive, ticks leave the count unchanged and halt_req produces no reset. A written count with bit 6 clear also produces no reset.
- R4: While active, each cycle with tick high and no write decrements the count by one, visible on rd_data after that clock edge.
- R5: A write loads bits 6..0 of wr_data into the count. A write takes priority over a tick in the same cycle.
- R6: While active, when ticks take the count from 40h to 3Fh, wdg_rst rises at the next clock edge after rd_data shows 3Fh.
- R7: While active, writing a count with bit 6 clear shows that value on rd_data after the write edge, and wdg_rst rises one edge later.
- R8: halt_req sampled high while active makes wdg_rst rise at that same clock edge.
- R9: wdg_rst stays high for exactly PULSE_LEN cycles (default 4). During the pulse rd_data reads 7Fh and writes and ticks are ignored. Afterwards the watchdog is inactive with count 7Fh.
- R10: While active, ticks that keep bit 6 of the count set never raise wdg_rst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write value: bit 7 activate, bits 6..0 count |
| tick | input | 1 | One-cycle prescaled count enable |
| halt_req | input | 1 | Processor HALT request |
| rd_data | output | 8 | Register contents: flag and count |
| wdg_rst | output | 1 | Watchdog reset pulse, active high |

## Verification
Register effects (loads, decrements, flag set) appear on rd_data right after the edge that samples the write or tick. A timeout or a short write raises wdg_rst one edge after rd_data shows bit 6 cleared. A HALT request raises wdg_rst at the sampling edge itself. The driver queues every expectation with its due cycle counted from that sampling edge, and the monitor compares only at the falling edge of that cycle. Pulse-length checks run edge by edge across all PULSE_LEN high cycles and the first low one after them.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    TRIP_NONE    = 2'd0,
    TRIP_TIMEOUT = 2'd1,
    TRIP_HALT    = 2'd2
  } trip_e;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [CNT_W:0]   wr_data,
  input  logic             tick,
  output logic             armed,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      armed <= 1'b0;
      count <= '1;
    end else if (wr_en) begin
      armed <= armed | wr_data[CNT_W];
      count <= wr_data[CNT_W-1:0];
    end else if (tick && armed) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_trip.sv
module wdog_trip (
  input  logic armed,
  input  logic count_msb,
  input  logic halt_req,
  input  logic busy,
  output logic fire
);
  import wdog_pkg::*;
  trip_e cause;

  always_comb begin
    cause = TRIP_NONE;
    if (armed && !busy) begin
      if (halt_req)        cause = TRIP_HALT;
      else if (!count_msb) cause = TRIP_TIMEOUT;
    end
  end

  assign fire = (cause != TRIP_NONE);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic active
);
  localparam int PCW = $clog2(PULSE_LEN + 1);
  logic [PCW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      left_q <= '0;
    end else if (fire) begin
      active <= 1'b1;
      left_q <= PCW'(PULSE_LEN - 1);
    end else if (active) begin
      if (left_q == '0) active <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int CNT_W     = 7,
  parameter int PULSE_LEN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CNT_W:0] wr_data,
  input  logic           tick,
  input  logic           halt_req,
  output logic [CNT_W:0] rd_data,
  output logic           wdg_rst
);
  logic             armed;
  logic [CNT_W-1:0] count;
  logic             fire;

  wdog_ctrl_reg #(.CNT_W(CNT_W)) u_reg (
    .clk(clk), .rst(rst), .clear(fire | wdg_rst),
    .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
    .armed(armed), .count(count)
  );

  wdog_trip u_trip (
    .armed(armed), .count_msb(count[CNT_W-1]),
    .halt_req(halt_req), .busy(wdg_rst), .fire(fire)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .active(wdg_rst)
  );

  assign rd_data = {armed, count};
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W     = 7,
  parameter int PULSE_LEN = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic           tick,
  input logic           halt_req,
  input logic [CNT_W:0] rd_data,
  input logic           wdg_rst
);
  localparam int RCW = $clog2(PULSE_LEN + 2);
  logic [RCW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)          run_q <= '0;
    else if (wdg_rst) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[CNT_W] |=> (rd_data[CNT_W] || wdg_rst));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[CNT_W] && !wdg_rst) |=> !wdg_rst);

  p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data[CNT_W] && rd_data[CNT_W-1] && tick && !wr_en && !halt_req && !wdg_rst)
      |=> (rd_data[CNT_W-1:0] == CNT_W'($past(rd_data[CNT_W-1:0]) - 1'b1)));

  p_timeout_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_data[CNT_W] && !rd_data[CNT_W-1] && !wdg_rst) |=> wdg_rst);

  p_halt_r8: assert property (@(posedge clk) disable iff (rst)
    (halt_req && rd_data[CNT_W] && !wdg_rst) |=> wdg_rst);

  p_pulse_max_r9: assert property (@(posedge clk) disable iff (rst)
    wdg_rst |-> (run_q < RCW'(PULSE_LEN)));

  p_pulse_len_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(wdg_rst) |-> (run_q == RCW'(PULSE_LEN)));

  p_pulse_state_r9: assert property (@(posedge clk) disable iff (rst)
    wdg_rst |-> (rd_data == {1'b0, {CNT_W{1'b1}}}));
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .tick(tick),
  .halt_req(halt_req), .rd_data(rd_data), .wdg_rst(wdg_rst)
);

// File: tb/wdog_top_tb.sv
`timescale 1ns/1ps
module wdog_top_tb;
  localparam int PULSE_LEN = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic       halt_req = 1'b0;
  logic [7:0] rd_data;
  logic       wdg_rst;

  wdog_top #(.CNT_W(7), .PULSE_LEN(PULSE_LEN)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .halt_req(halt_req), .rd_data(rd_data), .wdg_rst(wdg_rst)
  );

  always #4 clk = ~clk;

  typedef struct {
    int         due;
    bit         crd;
    logic [7:0] rd;
    bit         crst;
    logic       rs;
    string      tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  // monitor: compare due items at the falling edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        if (sb[i].crd) begin
          n_run++;
          if (rd_data !== sb[i].rd) begin
            n_fail++;
            $display("FAIL %s rd_data actual=%h expected=%h", sb[i].tag, rd_data, sb[i].rd);
          end
        end
        if (sb[i].crst) begin
          n_run++;
          if (wdg_rst !== sb[i].rs) begin
            n_fail++;
            $display("FAIL %s wdg_rst actual=%b expected=%b", sb[i].tag, wdg_rst, sb[i].rs);
          end
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(int dly, bit crd, logic [7:0] rd, bit crst, logic rs, string tag);
    item_t it;
    it.due = cyc + dly; it.crd = crd; it.rd = rd; it.crst = crst; it.rs = rs; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step(bit w, logic [7:0] d, bit tk, bit hl);
    wr_en = w; wr_data = d; tick = tk; halt_req = hl;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; tick = 1'b0; halt_req = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_at(1, 1, 8'h7F, 1, 1'b0, "R1 reset value");
    idle(1);

    // R3 inactive: ticks, halt, short count do nothing
    expect_at(1, 1, 8'h7F, 1, 1'b0, "R3 tick inactive");
    step(1'b0, 8'h00, 1'b1, 1'b0);
    expect_at(1, 1, 8'h7F, 1, 1'b0, "R3 halt inactive");
    step(1'b0, 8'h00, 1'b0, 1'b1);
    expect_at(1, 1, 8'h05, 1, 1'b0, "R3 R5 short load inactive");
    expect_at(2, 0, 8'h00, 1, 1'b0, "R3 no trip after short load");
    expect_at(3, 0, 8'h00, 1, 1'b0, "R3 no trip later");
    step(1'b1, 8'h05, 1'b0, 1'b0);
    idle(2);

    // R2 activate, R4 decrement
    expect_at(1, 1, 8'hD0, 1, 1'b0, "R2 activate");
    step(1'b1, 8'hD0, 1'b0, 1'b0);
    expect_at(1, 1, 8'hCF, 0, 1'b0, "R4 dec 1");
    step(1'b0, 8'h00, 1'b1, 1'b0);
    expect_at(1, 1, 8'hCE, 0, 1'b0, "R4 dec 2");
    step(1'b0, 8'h00, 1'b1, 1'b0);
    expect_at(1, 1, 8'hCE, 0, 1'b0, "R4 hold without tick");
    idle(1);
    expect_at(1, 1, 8'hE0, 1, 1'b0, "R2 flag sticky on zero write");
    step(1'b1, 8'h60, 1'b0, 1'b0);
    expect_at(1, 1, 8'hF0, 1, 1'b0, "R5 write beats tick");
    step(1'b1, 8'h70, 1'b1, 1'b0);

    // R10 ticks above 40h never trip
    expect_at(1, 1, 8'hC2, 1, 1'b0, "R10 load C2");
    step(1'b1, 8'hC2, 1'b0, 1'b0);
    expect_at(1, 1, 8'hC1, 1, 1'b0, "R10 tick to 41");
    step(1'b0, 8'h00, 1'b1, 1'b0);
    expect_at(1, 1, 8'hC0, 1, 1'b0, "R10 tick to 40");
    step(1'b0, 8'h00, 1'b1, 1'b0);
    expect_at(1, 0, 8'h00, 1, 1'b0, "R10 idle at 40");
    idle(1);

    // R6 roll 40h -> 3Fh, R9 pulse
    expect_at(1, 1, 8'hBF, 1, 1'b0, "R6 count shows 3F");
    expect_at(2, 1, 8'h7F, 1, 1'b1, "R6 trip next edge");
    for (int k = 3; k <= PULSE_LEN + 1; k++)
      expect_at(k, 1, 8'h7F, 1, 1'b1, "R9 pulse high");
    expect_at(PULSE_LEN + 2, 1, 8'h7F, 1, 1'b0, "R9 pulse ends inactive");
    step(1'b0, 8'h00, 1'b1, 1'b0);
    idle(1);
    step(1'b1, 8'hC5, 1'b1, 1'b0);   // ignored during pulse (R9)
    idle(PULSE_LEN);
    expect_at(1, 1, 8'h7F, 1, 1'b0, "R9 R3 inactive after pulse, halt ignored");
    step(1'b0, 8'h00, 1'b0, 1'b1);

    // R7 short write while active
    expect_at(1, 1, 8'hFF, 1, 1'b0, "R7 arm");
    step(1'b1, 8'hFF, 1'b0, 1'b0);
    expect_at(1, 1, 8'h90, 1, 1'b0, "R7 short value visible");
    expect_at(2, 1, 8'h7F, 1, 1'b1, "R7 trip one edge later");
    expect_at(PULSE_LEN + 2, 0, 8'h00, 1, 1'b0, "R9 pulse length after R7");
    step(1'b1, 8'h10, 1'b0, 1'b0);
    idle(PULSE_LEN + 2);

    // R8 halt while active
    expect_at(1, 1, 8'hFF, 1, 1'b0, "R8 arm");
    step(1'b1, 8'hFF, 1'b0, 1'b0);
    for (int k = 1; k <= PULSE_LEN; k++)
      expect_at(k, 1, 8'h7F, 1, 1'b1, "R8 R9 halt pulse");
    expect_at(PULSE_LEN + 1, 1, 8'h7F, 1, 1'b0, "R9 halt pulse ends");
    step(1'b0, 8'h00, 1'b0, 1'b1);
    idle(PULSE_LEN + 2);

    if (sb.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard residue actual=%0d expected=0", sb.size());
    end
    summary();
  end
endmodule